// File: doc/BRIEF.md
# Busy-Throttled Compressed Data Bus Master

This block moves compressed bytes between an on-chip code buffer and an external byte-wide memory bus, acting as the bus master. It has two directions. When encoding, a coder pushes bytes into the buffer and the block writes them out to memory one bus cycle per byte. When decoding, the block reads bytes from memory into the buffer and a decoder pops them. The buffer is a small FIFO inside the block. Its coder-side push and pop, together with its full and empty flags, form the block's internal interface.

Every bus cycle keeps the strobe high for a programmable number of clocks. The address holds steady during a cycle and steps by one after each completed cycle. External memory control can hold transfers off with a busy input. Busy is registered on the rising clock edge, so it has to be seen one clock before a cycle would start in order to suppress that cycle. A cycle that has already begun always runs to its end. When busy is released, transfers pick up again by themselves. While writes are held off, the coder keeps pushing until the buffer is full. The full flag then stalls the coder.

Top module: `cdm_master`

## Requirements
- R1: While reset is high, and on the first clock after it, the strobe is low, the address is zero, the buffer is empty (cb_empty=1) and not full (cb_full=0). Any bytes held before the reset are discarded.
- R2: The strobe of each bus cycle stays high for exactly L consecutive clocks. L is cyc_len, and a cyc_len of 0 or 1 is treated as 2. The address does not change while the strobe is high, and it goes up by one when the strobe falls.
- R3: With mode_rd=0 (encode), every cycle has mem_we=1. The bytes written are the bytes pushed by the coder, in push order, one byte per cycle.
- R4: If mem_busy is high at rising edge k, no bus cycle begins at edge k+1. No new cycle begins for as long as busy stays high.
- R5: A bus cycle in progress runs its full L clocks, whatever busy does during it.
- R6: After busy returns low, pending transfers start again with no other action. The first strobe appears within three clocks of the release.
- R7: In encode mode no cycle begins while the buffer is empty. When the last pushed byte has been written, the strobe stays low.
- R8: With mode_rd=1 (decode), every cycle has mem_we=0. mem_rdata is sampled on the last clock of the cycle and pushed into the buffer, and the decoder pops the bytes in address order. No read cycle begins while the buffer is full, so read cycles stop once DEPTH bytes are waiting.
- R9: The buffer holds DEPTH bytes. A coder push while cb_full=1 is ignored, and so is a decoder pop while cb_empty=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| mode_rd | input | 1 | 1 = decode (bus reads into buffer), 0 = encode (buffer written to bus) |
| cyc_len | input | LEN_W | Clocks per bus cycle; values below 2 act as 2 |
| mem_busy | input | 1 | Memory bus busy from external control, high = hold off |
| mem_addr | output | AW | Bus address, steps by one per completed cycle |
| mem_strobe | output | 1 | High during a bus cycle |
| mem_we | output | 1 | High during a write cycle, low during a read cycle |
| mem_wdata | output | 8 | Byte driven in a write cycle |
| mem_rdata | input | 8 | Byte returned by memory, sampled on a read cycle's last clock |
| cb_push | input | 1 | Coder pushes a byte (encode mode) |
| cb_push_data | input | 8 | Byte pushed by the coder |
| cb_full | output | 1 | Buffer holds DEPTH bytes |
| cb_pop | input | 1 | Decoder pops a byte (decode mode) |
| cb_pop_data | output | 8 | Oldest byte in the buffer |
| cb_empty | output | 1 | Buffer holds no bytes |

## Verification
The properties assume that mode_rd and cyc_len only change while no bus cycle is running, and that mem_rdata depends only on the address presented. The stimulus meets the first condition by changing direction or length only after the buffer has drained or while busy holds the bus idle. It meets the second by driving mem_rdata as a fixed function of mem_addr. Busy is raised and released on falling edges at chosen points: before any data arrives, and on the first clock of a strobe. This exercises both the suppression of a pending cycle and the completion of a running one.

// File: rtl/cdm_pkg.sv
package cdm_pkg;

    localparam int CDM_BYTE_W  = 8;
    localparam int CDM_MIN_LEN = 2;

    typedef enum logic {
        CYC_IDLE = 1'b0,
        CYC_RUN  = 1'b1
    } cyc_state_e;

    // context held for the bus cycle in flight
    typedef struct packed {
        logic                  rd;
        logic [CDM_BYTE_W-1:0] data;
    } xfer_ctx_t;

endpackage

// File: rtl/cdm_fifo.sv
module cdm_fifo #(
    parameter int DEPTH = 8,
    parameter int W     = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] pop_data,
    output logic         full,
    output logic         empty
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  store [DEPTH];
    logic [PW-1:0] wp, rp;
    logic [CW-1:0] fill;
    logic          do_push, do_pop;

    function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    assign full     = (fill == CW'(DEPTH));
    assign empty    = (fill == '0);
    assign do_push  = push && !full;
    assign do_pop   = pop && !empty;
    assign pop_data = store[rp];

    always_ff @(posedge clk) begin
        if (do_push) begin
            store[wp] <= push_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp   <= '0;
            rp   <= '0;
            fill <= '0;
        end else begin
            if (do_push) wp <= step(wp);
            if (do_pop)  rp <= step(rp);
            case ({do_push, do_pop})
                2'b10:   fill <= fill + CW'(1);
                2'b01:   fill <= fill - CW'(1);
                default: fill <= fill;
            endcase
        end
    end
endmodule

// File: rtl/cdm_cycle_ctrl.sv
module cdm_cycle_ctrl
    import cdm_pkg::*;
#(
    parameter int LEN_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             can_start,
    input  logic [LEN_W-1:0] cyc_len,
    output logic             start,
    output logic             done,
    output logic             active
);
    cyc_state_e       state;
    logic [LEN_W-1:0] len_q;
    logic [LEN_W-1:0] cnt;
    logic [LEN_W-1:0] len_eff;

    assign len_eff = (cyc_len < LEN_W'(CDM_MIN_LEN)) ? LEN_W'(CDM_MIN_LEN) : cyc_len;
    assign active  = (state == CYC_RUN);
    assign start   = (state == CYC_IDLE) && can_start;
    assign done    = active && (cnt == len_q - LEN_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= CYC_IDLE;
            cnt   <= '0;
            len_q <= LEN_W'(CDM_MIN_LEN);
        end else begin
            case (state)
                CYC_IDLE: begin
                    if (start) begin
                        state <= CYC_RUN;
                        cnt   <= '0;
                        len_q <= len_eff;
                    end
                end
                CYC_RUN: begin
                    if (done) begin
                        state <= CYC_IDLE;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + LEN_W'(1);
                    end
                end
                default: state <= CYC_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/cdm_addr_gen.sv
module cdm_addr_gen #(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          inc,
    output logic [AW-1:0] addr
);
    always_ff @(posedge clk) begin
        if (rst) begin
            addr <= '0;
        end else if (inc) begin
            addr <= addr + AW'(1);
        end
    end
endmodule

// File: rtl/cdm_master.sv
module cdm_master
    import cdm_pkg::*;
#(
    parameter int AW    = 16,
    parameter int DEPTH = 8,
    parameter int LEN_W = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  mode_rd,
    input  logic [LEN_W-1:0]      cyc_len,
    input  logic                  mem_busy,
    output logic [AW-1:0]         mem_addr,
    output logic                  mem_strobe,
    output logic                  mem_we,
    output logic [CDM_BYTE_W-1:0] mem_wdata,
    input  logic [CDM_BYTE_W-1:0] mem_rdata,
    input  logic                  cb_push,
    input  logic [CDM_BYTE_W-1:0] cb_push_data,
    output logic                  cb_full,
    input  logic                  cb_pop,
    output logic [CDM_BYTE_W-1:0] cb_pop_data,
    output logic                  cb_empty
);
    logic                  busy_q;
    xfer_ctx_t             ctx_q;
    logic                  can_start, start, done, active;
    logic                  buf_push, buf_pop, buf_full, buf_empty;
    logic                  rd_done;
    logic [CDM_BYTE_W-1:0] buf_wdata, buf_head;

    // busy is looked at one clock ahead of the start it may block
    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            ctx_q  <= '0;
        end else begin
            busy_q <= mem_busy;
            if (start) begin
                ctx_q.rd   <= mode_rd;
                ctx_q.data <= buf_head;
            end
        end
    end

    assign can_start = !busy_q && (mode_rd ? !buf_full : !buf_empty);

    cdm_cycle_ctrl #(.LEN_W(LEN_W)) u_cyc (
        .clk       (clk),
        .rst       (rst),
        .can_start (can_start),
        .cyc_len   (cyc_len),
        .start     (start),
        .done      (done),
        .active    (active)
    );

    cdm_addr_gen #(.AW(AW)) u_addr (
        .clk  (clk),
        .rst  (rst),
        .inc  (done),
        .addr (mem_addr)
    );

    assign rd_done   = done && ctx_q.rd;
    assign buf_push  = rd_done || (cb_push && !mode_rd);
    assign buf_wdata = rd_done ? mem_rdata : cb_push_data;
    assign buf_pop   = (start && !mode_rd) || (cb_pop && mode_rd);

    cdm_fifo #(.DEPTH(DEPTH), .W(CDM_BYTE_W)) u_buf (
        .clk       (clk),
        .rst       (rst),
        .push      (buf_push),
        .push_data (buf_wdata),
        .pop       (buf_pop),
        .pop_data  (buf_head),
        .full      (buf_full),
        .empty     (buf_empty)
    );

    assign mem_strobe  = active;
    assign mem_we      = active && !ctx_q.rd;
    assign mem_wdata   = ctx_q.data;
    assign cb_full     = buf_full;
    assign cb_empty    = buf_empty;
    assign cb_pop_data = buf_head;
endmodule

// File: rtl/cdm_master_chk.sv
module cdm_master_chk #(
    parameter int AW    = 16,
    parameter int LEN_W = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             mode_rd,
    input logic [LEN_W-1:0] cyc_len,
    input logic             mem_busy,
    input logic [AW-1:0]    mem_addr,
    input logic             mem_strobe,
    input logic             mem_we,
    input logic             cb_full,
    input logic             cb_empty
);
    logic [LEN_W:0] run_cnt;
    logic [LEN_W:0] want_len;

    function automatic logic [LEN_W:0] eff_len(input logic [LEN_W-1:0] l);
        return (l < LEN_W'(2)) ? (LEN_W+1)'(2) : {1'b0, l};
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            run_cnt  <= '0;
            want_len <= '0;
        end else begin
            if (mem_strobe) begin
                run_cnt <= run_cnt + (LEN_W+1)'(1);
                if (run_cnt == '0) want_len <= eff_len(cyc_len);
            end else begin
                run_cnt <= '0;
            end
        end
    end

    p_reset_idle_r1: assert property (@(posedge clk)
        rst |=> (!mem_strobe && mem_addr == '0 && cb_empty && !cb_full));

    p_width_r2: assert property (@(posedge clk) disable iff (rst)
        $fell(mem_strobe) |-> (run_cnt == want_len));

    p_addr_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (mem_strobe && $past(mem_strobe)) |-> $stable(mem_addr));

    p_addr_step_r2: assert property (@(posedge clk) disable iff (rst)
        $fell(mem_strobe) |-> (mem_addr == $past(mem_addr) + AW'(1)));

    p_dir_r3: assert property (@(posedge clk) disable iff (rst)
        mem_strobe |-> (mem_we == !mode_rd));

    p_busy_block_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_strobe) |-> !$past(mem_busy, 2));

    p_no_cut_r5: assert property (@(posedge clk) disable iff (rst)
        ($fell(mem_strobe) && $past(mem_busy)) |-> (run_cnt == want_len));

    p_no_write_empty_r7: assert property (@(posedge clk) disable iff (rst)
        ($rose(mem_strobe) && mem_we) |-> !$past(cb_empty));

    p_no_read_full_r8: assert property (@(posedge clk) disable iff (rst)
        ($rose(mem_strobe) && !mem_we) |-> !$past(cb_full));
endmodule

bind cdm_master cdm_master_chk #(.AW(AW), .LEN_W(LEN_W)) u_chk (.*);

// File: tb/tb_cdm_master.sv
module tb_cdm_master;
    localparam int AW    = 16;
    localparam int DEPTH = 8;
    localparam int LEN_W = 4;
    localparam int LOGN  = 128;
    localparam int NROW  = 6;
    // {rd, len[3:0], count[3:0]}; count unused for decode rows
    localparam logic [8:0] VEC [NROW] = '{
        {1'b0, 4'd2, 4'd3},
        {1'b0, 4'd5, 4'd4},
        {1'b1, 4'd3, 4'd0},
        {1'b0, 4'd1, 4'd2},
        {1'b1, 4'd0, 4'd0},
        {1'b0, 4'd7, 4'd5}
    };

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             mode_rd = 1'b0;
    logic [LEN_W-1:0] cyc_len = 4'd2;
    logic             mem_busy = 1'b0;
    logic [AW-1:0]    mem_addr;
    logic             mem_strobe, mem_we;
    logic [7:0]       mem_wdata, mem_rdata;
    logic             cb_push = 1'b0;
    logic [7:0]       cb_push_data = 8'h00;
    logic             cb_full;
    logic             cb_pop = 1'b0;
    logic [7:0]       cb_pop_data;
    logic             cb_empty;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;
    int exp_addr = 0;

    int          log_w  [LOGN];
    logic [AW-1:0] log_a [LOGN];
    logic [7:0]  log_d  [LOGN];
    logic        log_we [LOGN];
    int          log_cnt = 0;
    int          cur_w = 0;
    logic [AW-1:0] cur_a = '0;
    logic [7:0]  cur_d = '0;
    logic        cur_we = 1'b0;

    always #10 clk = ~clk;

    assign mem_rdata = mem_addr[7:0] ^ 8'h5A;

    cdm_master #(.AW(AW), .DEPTH(DEPTH), .LEN_W(LEN_W)) dut (
        .clk(clk), .rst(rst), .mode_rd(mode_rd), .cyc_len(cyc_len),
        .mem_busy(mem_busy), .mem_addr(mem_addr), .mem_strobe(mem_strobe),
        .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .cb_push(cb_push), .cb_push_data(cb_push_data), .cb_full(cb_full),
        .cb_pop(cb_pop), .cb_pop_data(cb_pop_data), .cb_empty(cb_empty)
    );

    // bus monitor, sampled on falling edges
    always @(negedge clk) begin
        if (mem_strobe) begin
            cur_w  = cur_w + 1;
            cur_a  = mem_addr;
            cur_d  = mem_wdata;
            cur_we = mem_we;
        end else if (cur_w > 0) begin
            if (log_cnt < LOGN) begin
                log_w[log_cnt]  = cur_w;
                log_a[log_cnt]  = cur_a;
                log_d[log_cnt]  = cur_d;
                log_we[log_cnt] = cur_we;
            end
            log_cnt = log_cnt + 1;
            cur_w = 0;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_clks(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    function automatic int eff(input int l);
        return (l < 2) ? 2 : l;
    endfunction

    task automatic check_cycle(input int idx, input int el, input bit we);
        chk(log_w[idx] == el, "R2 strobe width", log_w[idx], el);
        chk(int'(log_a[idx]) == exp_addr, "R2 address", int'(log_a[idx]), exp_addr);
        chk(log_we[idx] == we, we ? "R3 write direction" : "R8 read direction",
            int'(log_we[idx]), int'(we));
    endtask

    task automatic push_bytes(input int n, input logic [7:0] base);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            cb_push = 1'b1;
            cb_push_data = base + 8'(i);
        end
        @(negedge clk);
        cb_push = 1'b0;
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles == 150000) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, 0);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int base;
        wait_clks(3);
        chk(mem_strobe == 1'b0 && cb_empty == 1'b1, "R1 idle in reset",
            int'({mem_strobe, cb_empty}), 1);
        rst = 1'b0;
        chk(mem_addr == '0 && cb_full == 1'b0, "R1 address and full after reset",
            int'(mem_addr), 0);

        for (int r = 0; r < NROW; r++) begin
            int n, el;
            n  = int'(VEC[r][3:0]);
            el = eff(int'(VEC[r][7:4]));
            base = log_cnt;
            @(negedge clk);
            cyc_len = VEC[r][7:4];
            if (!VEC[r][8]) begin
                mode_rd = 1'b0;
                push_bytes(n, 8'h30 + 8'(r * 16));
                wait_clks(n * (el + 1) + 10);
                chk(log_cnt - base == n, "R7 write count", log_cnt - base, n);
                for (int k = 0; k < n; k++) begin
                    check_cycle(base + k, el, 1'b1);
                    chk(log_d[base + k] == 8'h30 + 8'(r * 16 + k), "R3 write data",
                        int'(log_d[base + k]), 'h30 + r * 16 + k);
                    exp_addr++;
                end
                chk(mem_strobe == 1'b0 && cb_empty == 1'b1, "R7 idle when empty",
                    int'(mem_strobe), 0);
            end else begin
                mode_rd = 1'b1;
                wait_clks(DEPTH * (el + 1) + 10);
                chk(log_cnt - base == DEPTH, "R8 reads stop at full", log_cnt - base, DEPTH);
                chk(cb_full == 1'b1, "R9 full flag", int'(cb_full), 1);
                mem_busy = 1'b1;
                wait_clks(el + 4);
                for (int k = 0; k < DEPTH; k++) begin
                    check_cycle(base + k, el, 1'b0);
                    chk(cb_pop_data == (8'(exp_addr) ^ 8'h5A), "R8 read data order",
                        int'(cb_pop_data), (exp_addr & 255) ^ 'h5A);
                    cb_pop = 1'b1;
                    @(negedge clk);
                    cb_pop = 1'b0;
                    @(negedge clk);
                    exp_addr++;
                end
                chk(cb_empty == 1'b1, "R9 drained", int'(cb_empty), 1);
                cb_pop = 1'b1;
                @(negedge clk);
                cb_pop = 1'b0;
                @(negedge clk);
                chk(cb_empty == 1'b1 && cb_full == 1'b0, "R9 pop on empty ignored",
                    int'({cb_full, cb_empty}), 1);
                mode_rd = 1'b0;
                wait_clks(2);
                mem_busy = 1'b0;
                wait_clks(6);
                chk(log_cnt - base == DEPTH, "R7 no write after empty pop",
                    log_cnt - base, DEPTH);
            end
        end

        // busy before data, busy during a cycle, release
        begin
            int got;
            base = log_cnt;
            cyc_len = 4'd4;
            mem_busy = 1'b1;
            wait_clks(2);
            push_bytes(3, 8'hA0);
            wait_clks(20);
            chk(log_cnt == base && mem_strobe == 1'b0, "R4 busy blocks start",
                log_cnt - base, 0);
            mem_busy = 1'b0;
            got = 0;
            for (int i = 0; i < 4 && got == 0; i++) begin
                @(negedge clk);
                if (mem_strobe) got = i + 1;
            end
            chk(got != 0 && got <= 3, "R6 resume after release", got, 3);
            mem_busy = 1'b1;
            wait_clks(15);
            chk(log_cnt - base == 1, "R4 no start while busy", log_cnt - base, 1);
            chk(log_w[base] == 4, "R5 running cycle completes", log_w[base], 4);
            mem_busy = 1'b0;
            wait_clks(30);
            chk(log_cnt - base == 3, "R6 remaining transfers", log_cnt - base, 3);
            for (int k = 0; k < 3; k++) begin
                check_cycle(base + k, 4, 1'b1);
                chk(log_d[base + k] == 8'hA0 + 8'(k), "R3 data after busy",
                    int'(log_d[base + k]), 'hA0 + k);
                exp_addr++;
            end
        end

        // coder overfills while writes are held off
        base = log_cnt;
        cyc_len = 4'd2;
        mem_busy = 1'b1;
        wait_clks(2);
        push_bytes(DEPTH + 2, 8'hC0);
        chk(cb_full == 1'b1 && cb_empty == 1'b0, "R9 fills while stalled",
            int'({cb_full, cb_empty}), 2);
        mem_busy = 1'b0;
        wait_clks(DEPTH * 3 + 12);
        chk(log_cnt - base == DEPTH, "R9 extra pushes ignored", log_cnt - base, DEPTH);
        for (int k = 0; k < DEPTH; k++) begin
            chk(log_d[base + k] == 8'hC0 + 8'(k), "R9 kept bytes",
                int'(log_d[base + k]), 'hC0 + k);
            check_cycle(base + k, 2, 1'b1);
            exp_addr++;
        end
        chk(cb_empty == 1'b1, "R7 empty after drain", int'(cb_empty), 1);

        // reset with data held and a nonzero address
        mem_busy = 1'b1;
        wait_clks(2);
        push_bytes(2, 8'h11);
        chk(mem_addr != '0 && cb_empty == 1'b0, "R1 precondition",
            int'(mem_addr), exp_addr);
        rst = 1'b1;
        wait_clks(2);
        rst = 1'b0;
        chk(mem_addr == '0 && cb_empty == 1'b1 && mem_strobe == 1'b0,
            "R1 reset clears", int'(mem_addr), 0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule